// File: doc/BRIEF.md
# Sixteen-Step Pulse Tone Channel

This block is a square-wave tone source for a sound subsystem. Three 8-bit control registers, written through a simple index/data port, set the loudness, the pulse width and the pitch of the tone. A 12-bit down-counter divides the input clock. Each time it expires, a sixteen-position sequencer moves one place. The channel drives a 4-bit amplitude that equals the programmed volume during the active part of each sixteen-step cycle and zero for the rest.

The active width can be set from one to eight sixteenths of the cycle. A hold bit bypasses the sequencer and keeps the output at the volume level for as long as it is set. A separate enable bit silences the channel. While the channel is disabled, the divider and the sequencer keep their values, so the tone resumes from the same position when it is enabled again. Mixing, conversion to analogue and resampling belong to other blocks.

Top module: `pulse_tone_ch`

## Requirements
- R1: The volume is `ctl[3:0]` (control register, index 0). When the channel produces sound, `amp` equals this value.
- R2: The width field is `ctl[6:4]`, and the active width is that field plus one steps out of 16. With the channel enabled and the hold bit clear, `amp` equals the volume while the step position is below the width and is 0 otherwise.
- R3: The hold bit `ctl[7]`, when set and the channel is enabled, keeps `amp` at the volume whatever the step position, and the sequencer does not advance while it is set.
- R4: The enable bit is bit 7 of index 2. While it is clear, `amp` is 0 and the divider and the step position keep their values.
- R5: The period is formed from index 1 (bits 7:0) and bits 3:0 of index 2 (bits 11:8). While the channel runs, the step position advances exactly once every period+1 clocks.
- R6: The step position counts upward and wraps from 15 to 0.
- R7: While the volume is 0, the sequencer does not advance.
- R8: A synchronous reset clears all registers, sets the divider count to 0 and the step position to 1, and drives `amp` to 0.
- R9: A register write changes `amp` from the clock edge that accepts it. A write does not change the divider count or the step position. A write to index 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index: 0 control, 1 period low, 2 period high and enable |
| wr_data | input | 8 | Write data |
| amp | output | 4 | Channel amplitude |

## Verification
The amplitude is combinational from registered state. The effect of a write, of a divider expiry or of reset therefore appears on `amp` directly after the clock edge that is active for that event, with no further register delay. The bench models the channel from the requirements and updates the model on each rising edge, using the same input values the design samples at that edge. It queues the expected amplitude and compares it at the next falling edge, so each result is checked one half-cycle after the edge that is due to produce it. The stimulus phases cover wrap-around, period timing, hold, disable, zero volume and the unused index. Each phase labels its comparisons with the requirement under test.

// File: rtl/pulse_tone_ch.sv
module pulse_tone_ch #(
  parameter int PER_W = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_idx,
  input  logic [7:0] wr_data,
  output logic [3:0] amp
);
  localparam int HI_W = PER_W - 8;

  logic [7:0]       ctl;
  logic [7:0]       per_lo;
  logic [HI_W-1:0]  per_hi;
  logic             en;
  logic [PER_W-1:0] cnt;
  logic [3:0]       step;

  logic [3:0]       vol;
  logic             gate;
  logic [3:0]       width;
  logic [PER_W-1:0] period;
  logic             run;
  logic             active;

  assign vol    = ctl[3:0];
  assign gate   = ctl[7];
  assign width  = {1'b0, ctl[6:4]} + 4'd1;
  assign period = {per_hi, per_lo};
  assign run    = en && !gate && (vol != 4'd0);
  assign active = gate || (step < width);
  assign amp    = (en && active) ? vol : 4'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl    <= '0;
      per_lo <= '0;
      per_hi <= '0;
      en     <= 1'b0;
      cnt    <= '0;
      step   <= 4'd1;
    end else begin
      if (run) begin
        if (cnt == '0) begin
          cnt  <= period;
          step <= step + 4'd1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (wr_en) begin
        case (wr_idx)
          2'd0: ctl <= wr_data;
          2'd1: per_lo <= wr_data;
          2'd2: begin
            per_hi <= wr_data[HI_W-1:0];
            en     <= wr_data[7];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pulse_tone_ch_chk.sv
module pulse_tone_ch_chk #(
  parameter int PER_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       amp,
  input logic [3:0]       vol,
  input logic             gate,
  input logic             en,
  input logic [3:0]       step,
  input logic [PER_W-1:0] cnt
);
  p_amp_bound_r1: assert property (@(posedge clk) disable iff (rst)
    amp <= vol);

  // R3
  p_hold_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    (en && gate) |=> $stable(step));

  // R4
  p_off_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(step) && $stable(cnt)));

  // R5, R6
  p_step_on_expiry_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(step) |-> ($past(cnt) == '0 && step == $past(step) + 4'd1));

  // R7
  p_silent_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (vol == 4'd0) |=> $stable(step));

  // R8
  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> (step == 4'd1 && amp == 4'd0 && cnt == '0));
endmodule

bind pulse_tone_ch pulse_tone_ch_chk #(.PER_W(PER_W)) chk_i (
  .clk(clk), .rst(rst), .amp(amp), .vol(vol), .gate(gate),
  .en(en), .step(step), .cnt(cnt)
);

// File: tb/pulse_tone_ch_tb_top.sv
module pulse_tone_ch_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] amp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R8";

  logic [3:0] expq[$];

  logic [7:0]  m_ctl, m_lo;
  logic [3:0]  m_hi;
  logic        m_en;
  logic [11:0] m_cnt;
  logic [3:0]  m_step;

  always #10 clk = ~clk;

  pulse_tone_ch dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .amp(amp)
  );

  // Reference model, updated at each rising edge from the requirements
  always @(posedge clk) begin
    logic [3:0] v;
    logic [3:0] w;
    logic [3:0] e;
    if (rst) begin
      m_ctl = '0; m_lo = '0; m_hi = '0; m_en = 1'b0;
      m_cnt = '0; m_step = 4'd1;
    end else begin
      if (m_en && !m_ctl[7] && m_ctl[3:0] != 4'd0) begin
        if (m_cnt == 12'd0) begin
          m_cnt = {m_hi, m_lo};
          m_step = (m_step == 4'd15) ? 4'd0 : m_step + 4'd1;
        end else begin
          m_cnt = m_cnt - 12'd1;
        end
      end
      if (wr_en) begin
        if (wr_idx == 2'd0) m_ctl = wr_data;
        else if (wr_idx == 2'd1) m_lo = wr_data;
        else if (wr_idx == 2'd2) begin m_hi = wr_data[3:0]; m_en = wr_data[7]; end
      end
    end
    v = m_ctl[3:0];
    w = {1'b0, m_ctl[6:4]} + 4'd1;
    if (!m_en) e = 4'd0;
    else if (m_ctl[7] || m_step < w) e = v;
    else e = 4'd0;
    expq.push_back(e);
  end

  // Monitor: compare half a cycle after the edge
  always @(negedge clk) begin
    logic [3:0] e;
    if (!done && expq.size() != 0) begin
      e = expq.pop_front();
      checks++;
      if (amp !== e) begin
        errors++;
        $display("FAIL %s: amp=%0d expected=%0d at %0t", tag, amp, e, $time);
      end
    end
  end

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R8 reset";
    idle(4);
    rst = 1'b0;
    idle(3);

    tag = "R7 zero volume, R9 write order";
    wr(2'd1, 8'd3);
    wr(2'd2, 8'h80);
    idle(10);

    tag = "R1 R2 R5 R6 volume 9 width 4 period 3";
    wr(2'd0, 8'h39);
    idle(160);

    tag = "R2 width 1 period 0";
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h0F);
    idle(40);

    tag = "R2 width 8";
    wr(2'd0, 8'h7C);
    idle(40);

    tag = "R3 hold";
    wr(2'd1, 8'd2);
    wr(2'd0, 8'hA6);
    idle(30);
    tag = "R3 hold released";
    wr(2'd0, 8'h26);
    idle(60);

    tag = "R4 disabled";
    wr(2'd2, 8'h00);
    idle(30);
    tag = "R4 re-enabled";
    wr(2'd2, 8'h80);
    idle(60);

    tag = "R9 index 3 ignored";
    wr(2'd3, 8'hFF);
    idle(20);

    tag = "R7 volume zero mid-run";
    wr(2'd0, 8'h20);
    idle(20);
    wr(2'd0, 8'h2B);
    idle(40);

    tag = "R5 period with high bits";
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h81);
    idle(1400);

    tag = "R8 reset mid-run";
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule